// File: doc/BRIEF.md
# Match-Compare Timer with Watchdog Channel

The block is a timer peripheral for a larger chip. A free-running 32-bit up-counter advances once on each clock cycle in which `tick_i` is high. In the target system that strobe comes at 1 MHz, so the count is in microseconds. Six 32-bit compare channels each hold a match value. When a tick carries the counter onto a channel's value, that channel sets a sticky status bit. Software clears the bit by writing 1 to it, and a combined interrupt goes out for every status bit whose enable bit is set.

Channel 5 also serves as the watchdog. Its match raises a 16-cycle reset request, but only when the watchdog enable bit and channel 5's interrupt-enable bit are both set. Software keeps the system alive in three steps. It writes the latch command to take a coherent snapshot of the counter, reads the snapshot back, and writes the snapshot plus the timeout into match register 5.

The remaining time is match 5 minus the counter, computed with 32-bit wrap. The bus is a plain single-cycle register port: one write strobe, with read data decoded from the address alone.

Top module: `mtimer_wdog`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and `rst_req_o` is 0.
- R2: The counter, at offset 0x00, adds 1 on each clock edge where `tick_i` is high and wraps from 0xFFFFFFFF to 0. A bus write to 0x00 loads the counter and takes priority over a tick in the same cycle.
- R3: Match register n sits at offset 0x08 + 4*n, for n from 0 to 5. When a tick moves the counter onto the value in match register n, status bit n becomes 1 on that same edge. This also holds when the step is the wrap from 0xFFFFFFFF to 0. Loading the counter with a bus write is not a match.
- R4: The status register sits at offset 0x2C, with bit n belonging to channel n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a match and a clear land on the same edge, the match wins.
- R5: The interrupt enable register sits at offset 0x24, bits 5:0. `irq_o` is the OR over all channels of status bit n AND enable bit n. A status bit still gets set when its enable bit is 0.
- R6: Writing a value with bit 0 set to offset 0x30 copies the counter value from before that edge into the snapshot register at 0x34. Writing bit 0 = 0 leaves the snapshot unchanged. Offset 0x30 reads as 0.
- R7: A channel 5 match, with watchdog enable (offset 0x28, bit 0) = 1 and interrupt-enable bit 5 = 1, sets `rst_req_o` on the match edge. It then holds high for exactly 16 clock cycles.
- R8: A channel 5 match raises no reset request if the watchdog enable bit is 0, or if interrupt-enable bit 5 is 0. Status bit 5 is still set in either case.
- R9: Once `rst_req_o` is high, no register write can drop it before its 16 cycles are complete.
- R10: Writing snapshot + timeout into match register 5 before the counter gets there moves the expiry point out. Match 5 minus the counter, read over the bus, gives the ticks left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance strobe (1 MHz in the target system) |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address for both read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Combined masked interrupt |
| rst_req_o | output | 1 | Watchdog reset request pulse |

## Verification
Some rules are checked on every cycle by the assertions:
- the counter steps by exactly one on a tick and holds otherwise;
- status bits appear only on a tick edge;
- a latch command captures the counter;
- the reset pulse cannot end early;
- the reset pulse never starts while either enable is clear.

Other behaviour only the bench scenarios can show:
- that each of the six channels fires on exactly the tick that reaches its value, including across the wrap;
- that masking affects only `irq_o`;
- that the pulse lasts exactly 16 cycles;
- that moving match 5 ahead prevents the reset.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int unsigned CNT_W    = 32;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned NUM_CH   = 6;
  localparam int unsigned WD_CH    = 5;
  localparam int unsigned RST_CYC  = 16;

  localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MATCH = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_WDEN  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_STS   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_LATCH = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_SNAP  = 8'h34;
endpackage

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] nxt_o,
  output logic          adv_o
);
  logic [CW-1:0] cnt_q;

  assign nxt_o = cnt_q + CW'(1);
  assign adv_o = tick_i & ~load_i;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= nxt_o;
  end

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/mtimer_match.sv
module mtimer_match #(
  parameter int unsigned CW = 32,
  parameter int unsigned NCH = 6
) (
  input  logic [NCH-1:0][CW-1:0] match_i,
  input  logic [CW-1:0]          nxt_i,
  input  logic                   adv_i,
  output logic [NCH-1:0]         hit_o
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    // modular equality on the incoming value handles the wrap
    assign hit_o[n] = adv_i && (nxt_i == match_i[n]);
  end
endmodule

// File: rtl/mtimer_rstgen.sv
module mtimer_rstgen #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rst_o
);
  localparam int unsigned LW = (LEN > 1) ? $clog2(LEN) : 1;
  logic          act_q;
  logic [LW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else if (!act_q) begin
      if (trig_i) begin
        act_q <= 1'b1;
        rem_q <= LW'(LEN - 1);
      end
    end else if (rem_q == '0) begin
      act_q <= 1'b0;
    end else begin
      rem_q <= rem_q - LW'(1);
    end
  end

  assign rst_o = act_q;

  a_r9_no_early_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && rem_q != '0) |=> act_q);
  a_r7_start_on_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && trig_i) |=> act_q);
endmodule

// File: rtl/mtimer_wdog.sv
module mtimer_wdog
  import mtimer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [NUM_CH-1:0][CNT_W-1:0] match_q;
  logic [NUM_CH-1:0]            ien_q, sts_q, hit, clr;
  logic                         wden_q;
  logic [CNT_W-1:0]             snap_q, cnt, nxt;
  logic                         adv, cnt_ld, wd_trig;
  logic [NUM_CH-1:0]            match_sel;

  assign cnt_ld = wr_i && (addr_i == OFS_CNT);

  mtimer_counter #(.CW(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .load_i(cnt_ld), .load_val_i(wdata_i),
    .cnt_o(cnt), .nxt_o(nxt), .adv_o(adv)
  );

  mtimer_match #(.CW(CNT_W), .NCH(NUM_CH)) u_match (
    .match_i(match_q), .nxt_i(nxt), .adv_i(adv), .hit_o(hit)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_sel
    assign match_sel[n] = (addr_i == ADDR_W'(OFS_MATCH + ADDR_W'(4 * n)));
  end

  assign clr = (wr_i && addr_i == OFS_STS) ? wdata_i[NUM_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      ien_q   <= '0;
      wden_q  <= 1'b0;
      sts_q   <= '0;
      snap_q  <= '0;
    end else begin
      if (wr_i) begin
        for (int n = 0; n < NUM_CH; n++)
          if (match_sel[n]) match_q[n] <= wdata_i;
        if (addr_i == OFS_IEN)  ien_q  <= wdata_i[NUM_CH-1:0];
        if (addr_i == OFS_WDEN) wden_q <= wdata_i[0];
        if (addr_i == OFS_LATCH && wdata_i[0]) snap_q <= cnt;
      end
      sts_q <= (sts_q & ~clr) | hit;
    end
  end

  assign wd_trig = hit[WD_CH] & wden_q & ien_q[WD_CH];

  mtimer_rstgen #(.LEN(RST_CYC)) u_rst (
    .clk_i, .rst_ni, .trig_i(wd_trig), .rst_o(rst_req_o)
  );

  assign irq_o = |(sts_q & ien_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CNT:  rdata_o = cnt;
      OFS_IEN:  rdata_o = CNT_W'(ien_q);
      OFS_WDEN: rdata_o = CNT_W'(wden_q);
      OFS_STS:  rdata_o = CNT_W'(sts_q);
      OFS_SNAP: rdata_o = snap_q;
      default:  rdata_o = '0;
    endcase
    for (int n = 0; n < NUM_CH; n++)
      if (match_sel[n]) rdata_o = match_q[n];
  end

  a_r3_set_on_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ((sts_q & ~$past(sts_q)) == '0));
  a_r6_latch_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_LATCH && wdata_i[0]) |=> (snap_q == $past(cnt)));
  a_r8_no_start_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_o && !(wden_q && ien_q[WD_CH])) |=> !rst_req_o);
endmodule

// File: tb/mtimer_wdog_bench.sv
module mtimer_wdog_bench;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, rstq;
  int          checks = 0, errors = 0;
  logic [31:0] tmp, tmp2;

  always #10 clk = ~clk;

  mtimer_wdog u_mtimer_wdog (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rstq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(a, v); chk(req, v, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic count_pulse(output int hi);
    hi = 0;
    for (int i = 0; i < 24; i++) begin
      if (rstq) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: bench timeout, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 'h38; a += 4) rd_chk("R1", 8'(a), 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rst", {31'b0, rstq}, 32'h0);
    rst_n = 1'b1;

    // R2 load and step
    wr_reg(8'h00, 32'd100);
    ticks(5);
    rd_chk("R2 step", 8'h00, 32'd105);
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 8'h00; wdata = 32'd7;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    rd_chk("R2 load priority", 8'h00, 32'd7);

    // R3 R4 R5 sweep of every channel
    wr_reg(8'h24, 32'h3F);
    for (int n = 0; n < 6; n++) begin
      rd_reg(8'h00, tmp);
      wr_reg(8'(8 + 4 * n), tmp + 32'd3);
      rd_chk("R3 match rd", 8'(8 + 4 * n), tmp + 32'd3);
      ticks(2);
      rd_chk("R3 early", 8'h2C, 32'h0);
      ticks(1);
      rd_chk("R3 hit", 8'h2C, 32'(1) << n);
      chk("R5 irq on", {31'b0, irq}, 32'h1);
      wr_reg(8'h2C, 32'h0);
      rd_chk("R4 write0 keeps", 8'h2C, 32'(1) << n);
      wr_reg(8'h2C, 32'(1) << n);
      rd_chk("R4 w1c", 8'h2C, 32'h0);
      chk("R5 irq off", {31'b0, irq}, 32'h0);
    end

    // R5 masked
    wr_reg(8'h24, 32'h3E);
    rd_reg(8'h00, tmp);
    wr_reg(8'h08, tmp + 32'd1);
    ticks(1);
    rd_chk("R5 sts unmasked", 8'h2C, 32'h1);
    chk("R5 masked irq", {31'b0, irq}, 32'h0);
    wr_reg(8'h2C, 32'h3F);

    // R4 set wins over clear
    rd_reg(8'h00, tmp);
    wr_reg(8'h08, tmp + 32'd1);
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 8'h2C; wdata = 32'h1;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    rd_chk("R4 set wins", 8'h2C, 32'h1);
    wr_reg(8'h2C, 32'h3F);

    // R3 across wrap
    wr_reg(8'h00, 32'hFFFF_FFFE);
    wr_reg(8'h0C, 32'h0000_0001);
    ticks(2);
    rd_chk("R2 wrap", 8'h00, 32'h0);
    rd_chk("R3 pre-wrap", 8'h2C, 32'h0);
    ticks(1);
    rd_chk("R3 wrap hit", 8'h2C, 32'h2);
    wr_reg(8'h2C, 32'h3F);
    // R3 load onto value is not a match
    wr_reg(8'h0C, 32'd50);
    wr_reg(8'h00, 32'd50);
    rd_chk("R3 load no hit", 8'h2C, 32'h0);

    // R6 latch
    wr_reg(8'h00, 32'd1234);
    wr_reg(8'h30, 32'h1);
    ticks(4);
    rd_chk("R6 snap", 8'h34, 32'd1234);
    rd_chk("R6 cnt moved", 8'h00, 32'd1238);
    wr_reg(8'h30, 32'h0);
    rd_chk("R6 bit0 clear", 8'h34, 32'd1234);
    rd_chk("R6 latch reads 0", 8'h30, 32'h0);

    // R8 watchdog disabled / bit5 clear
    wr_reg(8'h24, 32'h3F);
    wr_reg(8'h28, 32'h0);
    rd_reg(8'h00, tmp);
    wr_reg(8'h1C, tmp + 32'd2);
    ticks(2);
    count_pulse(hi);
    chk("R8 wden off", 32'(hi), 32'h0);
    rd_chk("R8 sts5 wden off", 8'h2C, 32'h20);
    wr_reg(8'h2C, 32'h3F);
    wr_reg(8'h24, 32'h1F);
    wr_reg(8'h28, 32'h1);
    rd_chk("R8 wden rd", 8'h28, 32'h1);
    rd_reg(8'h00, tmp);
    wr_reg(8'h1C, tmp + 32'd2);
    ticks(2);
    count_pulse(hi);
    chk("R8 ien5 off", 32'(hi), 32'h0);
    rd_chk("R8 sts5 ien5 off", 8'h2C, 32'h20);
    wr_reg(8'h2C, 32'h3F);

    // R10 rearm keeps ahead
    wr_reg(8'h24, 32'h20);
    for (int k = 0; k < 4; k++) begin
      wr_reg(8'h30, 32'h1);
      rd_reg(8'h34, tmp);
      wr_reg(8'h1C, tmp + 32'd10);
      ticks(6);
      chk("R10 no reset", {31'b0, rstq}, 32'h0);
    end
    rd_reg(8'h1C, tmp); rd_reg(8'h00, tmp2);
    chk("R10 time left", tmp - tmp2, 32'd4);
    rd_chk("R10 no sts", 8'h2C, 32'h0);

    // R7 pulse length
    ticks(4);
    count_pulse(hi);
    chk("R7 pulse len", 32'(hi), 32'd16);
    wr_reg(8'h2C, 32'h3F);

    // R9 no cancel
    rd_reg(8'h00, tmp);
    wr_reg(8'h1C, tmp + 32'd1);
    ticks(1);
    chk("R9 started", {31'b0, rstq}, 32'h1);
    wr_reg(8'h28, 32'h0);
    wr_reg(8'h24, 32'h0);
    chk("R9 held", {31'b0, rstq}, 32'h1);
    count_pulse(hi);
    chk("R9 remaining", 32'(hi), 32'd12);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule